// File: doc/BRIEF.md
# Operating-Point Table Lookup Engine

This block keeps a small table of operating points for each processor cluster. Each point pairs a clock frequency with a supply voltage. The table is filled through a load port, one packed 32-bit word at a time. Each word is split into a 12-bit voltage code and a 20-bit raw frequency. The raw frequency is scaled by twenty to give kHz.

Entries must arrive in index order. The first load that is reported as failed closes the table of that cluster. The number of entries loaded before that point becomes the valid-entry count.

A query port serves three lookups:
- read the frequency stored at an index,
- find the first index whose frequency equals a given value,
- round a requested frequency to a supported one.

Each query walks the table one slot per clock. It then returns a one-cycle result pulse carrying a value, the chosen entry's voltage code and an error flag. A frequency-scaling controller uses it to check or pick a target point before applying it elsewhere.

Top module: `opp_table_engine`

## Requirements
- R1: A load word carries the voltage code in bits 31:20 and a raw frequency in bits 19:0. A get query (opcode 0, operand = index) returns raw×20 in `r_value` and the voltage code in `r_volt`.
- R2: A load with `ld_ok`=1 is stored only if its index equals the cluster's current count and the count is below 8. A stored load raises the count by one. Out-of-order loads and loads into a full table leave the table unchanged.
- R3: A load with `ld_ok`=0 closes the table of that cluster. Later loads to that cluster are ignored until reset.
- R4: Each cluster (`ld_cluster`/`q_cluster` = 0 or 1) has its own entries and count. A query sees only the entries of the cluster it names.
- R5: A get query whose index is at or above the valid count returns `r_err`=1. Every result with `r_err`=1 carries `r_value`=0 and `r_volt`=0.
- R6: A match query (opcode 1, operand in kHz) returns the lowest index whose frequency equals the operand, together with that entry's voltage code.
- R7: A match query with no equal entry returns `r_err`=1.
- R8: A round query (opcode 2, operand in kHz) returns the smallest stored frequency at or above the operand. On a tie the lower index supplies the voltage code.
- R9: When no stored frequency reaches the operand, a round query returns the largest stored frequency below it.
- R10: A round query on a cluster with no valid entries returns `r_err`=1 with zero value.
- R11: A query is accepted on a clock edge where `q_valid`=1 and `q_busy`=0. `q_busy` then stays high until `r_valid` pulses for exactly one cycle, 9 edges after acceptance. `q_valid` is ignored while busy.
- R12: Opcode 3 is reserved and returns `r_err`=1.
- R13: After reset both tables are empty, `q_busy`=0 and `r_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load strobe |
| ld_ok | input | 1 | 1: word fetched successfully; 0: fetch failed |
| ld_cluster | input | 1 | Cluster the load targets |
| ld_index | input | 3 | Table index of the load |
| ld_word | input | 32 | Packed voltage/frequency word |
| q_valid | input | 1 | Query strobe |
| q_cluster | input | 1 | Cluster the query searches |
| q_op | input | 2 | 0 get, 1 match, 2 round, 3 reserved |
| q_operand | input | 25 | Index (get) or frequency in kHz (match, round) |
| q_busy | output | 1 | A query is being scanned |
| r_valid | output | 1 | One-cycle result pulse |
| r_err | output | 1 | Query failed |
| r_value | output | 25 | Frequency in kHz (get, round) or index (match) |
| r_volt | output | 12 | Voltage code of the selected entry |

## Verification
The hardest case to reach is a table whose count froze at a failed load while a well-formed word for the next index followed. Only queries can show that this later word never entered the table. The stimulus loads five entries into one cluster, reports a failed load, and then offers a valid word for index 5. Get and match queries aimed at that word must return errors.

A second hard case is a table that is full. Its 3-bit index wraps, so a load to index 0 would otherwise overwrite the first entry. The bench fills all eight slots, offers index 0 again, and reads entry 0 back unchanged.

Duplicate frequencies at two indices check the first-match and tie-breaking rules. A query raised while another is in flight checks that the second query is dropped.

// File: rtl/opp_pkg.sv
// Shared definitions of the operating-point table engine.
// Assumes: the query opcode is two bits wide.
package opp_pkg;

    typedef enum logic [1:0] {
        OP_GET   = 2'd0,
        OP_MATCH = 2'd1,
        OP_ROUND = 2'd2,
        OP_RSVD  = 2'd3
    } opp_op_e;

endpackage

// File: rtl/opp_unpack.sv
// Splits a packed load word into a voltage code and a kHz frequency.
// Assumes: voltage sits in the upper VOLT_W bits, the raw frequency in the
// lower RAW_W bits, and FREQ_W is wide enough for raw * SCALE.
module opp_unpack #(
    parameter int RAW_W  = 20,
    parameter int VOLT_W = 12,
    parameter int SCALE  = 20,
    parameter int FREQ_W = 25,
    localparam int WORD_W = RAW_W + VOLT_W
) (
    input  logic [WORD_W-1:0] word,
    output logic [FREQ_W-1:0] freq,
    output logic [VOLT_W-1:0] volt
);

    logic [RAW_W-1:0] raw;

    assign raw  = word[RAW_W-1:0];
    assign volt = word[WORD_W-1 -: VOLT_W];

    // A unit scale needs no multiplier.
    generate
        if (SCALE == 1) begin : g_noscale
            assign freq = FREQ_W'(raw);
        end else begin : g_scale
            assign freq = FREQ_W'(raw) * FREQ_W'(SCALE);
        end
    endgenerate

endmodule

// File: rtl/opp_store.sv
// Register table of operating points per cluster, with in-order loading,
// a valid-entry count and a per-cluster seal set by a failed load.
// Assumes: NUM_CL is a power of two; read ports are combinational.
module opp_store #(
    parameter int NUM_CL  = 2,
    parameter int MAX_PTS = 8,
    parameter int FREQ_W  = 25,
    parameter int VOLT_W  = 12,
    localparam int CL_W   = $clog2(NUM_CL),
    localparam int IDX_W  = $clog2(MAX_PTS),
    localparam int CNT_W  = $clog2(MAX_PTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_ok,
    input  logic [CL_W-1:0]   wr_cluster,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [FREQ_W-1:0] wr_freq,
    input  logic [VOLT_W-1:0] wr_volt,
    input  logic [CL_W-1:0]   rd_cluster,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [FREQ_W-1:0] rd_freq,
    output logic [VOLT_W-1:0] rd_volt,
    input  logic [CL_W-1:0]   cnt_cluster,
    output logic [CNT_W-1:0]  cnt_value
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_PTS);

    logic [FREQ_W-1:0] freq_q  [NUM_CL][MAX_PTS];
    logic [VOLT_W-1:0] volt_q  [NUM_CL][MAX_PTS];
    logic [CNT_W-1:0]  count_q [NUM_CL];
    logic [NUM_CL-1:0] sealed_q;

    // Accept in-order loads, or seal the cluster on a failed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sealed_q <= '0;
            for (int c = 0; c < NUM_CL; c++) begin
                count_q[c] <= '0;
                for (int i = 0; i < MAX_PTS; i++) begin
                    freq_q[c][i] <= '0;
                    volt_q[c][i] <= '0;
                end
            end
        end else if (wr_valid && !sealed_q[wr_cluster]) begin
            if (!wr_ok) begin
                sealed_q[wr_cluster] <= 1'b1;
            end else if (count_q[wr_cluster] != FULL &&
                         CNT_W'(wr_index) == count_q[wr_cluster]) begin
                freq_q[wr_cluster][wr_index] <= wr_freq;
                volt_q[wr_cluster][wr_index] <= wr_volt;
                count_q[wr_cluster]          <= count_q[wr_cluster] + CNT_W'(1);
            end
        end
    end

    // Combinational read of one entry and of one cluster's count.
    assign rd_freq   = freq_q[rd_cluster][rd_index];
    assign rd_volt   = volt_q[rd_cluster][rd_index];
    assign cnt_value = count_q[cnt_cluster];

    generate
        for (genvar c = 0; c < NUM_CL; c++) begin : g_chk
            p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
                count_q[c] <= FULL);
            p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (count_q[c] == $past(count_q[c])) ||
                (count_q[c] == $past(count_q[c]) + CNT_W'(1)));
            p_sealed_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
                sealed_q[c] |=> $stable(count_q[c]));
        end
    endgenerate

endmodule

// File: rtl/opp_scan.sv
// Query sequencer: latches a query, visits every table slot once per clock,
// keeps running candidates, then emits a one-cycle result pulse.
// Assumes: the table of the queried cluster is not loaded while scanning.
module opp_scan
    import opp_pkg::*;
#(
    parameter int NUM_CL  = 2,
    parameter int MAX_PTS = 8,
    parameter int FREQ_W  = 25,
    parameter int VOLT_W  = 12,
    localparam int CL_W   = $clog2(NUM_CL),
    localparam int IDX_W  = $clog2(MAX_PTS),
    localparam int CNT_W  = $clog2(MAX_PTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [CL_W-1:0]   q_cluster,
    input  logic [1:0]        q_op,
    input  logic [FREQ_W-1:0] q_operand,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic [CL_W-1:0]   rd_cluster,
    output logic [IDX_W-1:0]  rd_index,
    input  logic [FREQ_W-1:0] rd_freq,
    input  logic [VOLT_W-1:0] rd_volt,
    output logic              busy,
    output logic              r_valid,
    output logic              r_err,
    output logic [FREQ_W-1:0] r_value,
    output logic [VOLT_W-1:0] r_volt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_PTS);

    logic              busy_q, r_valid_q, r_err_q;
    logic [CNT_W-1:0]  step_q, cnt_q;
    logic [CL_W-1:0]   cl_q;
    opp_op_e           op_q;
    logic [FREQ_W-1:0] opnd_q, r_value_q;
    logic [VOLT_W-1:0] r_volt_q;
    logic              hit_v, ge_v, lt_v;
    logic [IDX_W-1:0]  hit_i;
    logic [FREQ_W-1:0] hit_f, ge_f, lt_f;
    logic [VOLT_W-1:0] hit_vlt, ge_vlt, lt_vlt;
    logic              res_err;
    logic [FREQ_W-1:0] res_val;
    logic [VOLT_W-1:0] res_volt;

    assign rd_cluster = cl_q;
    assign rd_index   = step_q[IDX_W-1:0];

    // Final answer from the candidates gathered over the scan.
    always_comb begin
        res_err  = 1'b1;
        res_val  = '0;
        res_volt = '0;
        case (op_q)
            OP_GET: if (hit_v) begin
                res_err = 1'b0; res_val = hit_f; res_volt = hit_vlt;
            end
            OP_MATCH: if (hit_v) begin
                res_err = 1'b0; res_val = FREQ_W'(hit_i); res_volt = hit_vlt;
            end
            OP_ROUND: if (ge_v) begin
                res_err = 1'b0; res_val = ge_f; res_volt = ge_vlt;
            end else if (lt_v) begin
                res_err = 1'b0; res_val = lt_f; res_volt = lt_vlt;
            end
            default: res_err = 1'b1;
        endcase
    end

    // Sequencer: accept, step through all slots, then publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            r_valid_q <= 1'b0;
            r_err_q   <= 1'b0;
            r_value_q <= '0;
            r_volt_q  <= '0;
            step_q    <= '0;
            cnt_q     <= '0;
            cl_q      <= '0;
            op_q      <= OP_GET;
            opnd_q    <= '0;
        end else begin
            r_valid_q <= 1'b0;
            if (!busy_q) begin
                if (q_valid) begin
                    busy_q <= 1'b1;
                    step_q <= '0;
                    cl_q   <= q_cluster;
                    op_q   <= opp_op_e'(q_op);
                    opnd_q <= q_operand;
                    cnt_q  <= cnt_in;
                end
            end else if (step_q != LAST) begin
                step_q <= step_q + CNT_W'(1);
            end else begin
                busy_q    <= 1'b0;
                r_valid_q <= 1'b1;
                r_err_q   <= res_err;
                r_value_q <= res_val;
                r_volt_q  <= res_volt;
            end
        end
    end

    // Candidate update for the slot visited this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {hit_v, ge_v, lt_v} <= '0;
            hit_i <= '0;
            {hit_f, ge_f, lt_f} <= '0;
            {hit_vlt, ge_vlt, lt_vlt} <= '0;
        end else if (!busy_q) begin
            if (q_valid) {hit_v, ge_v, lt_v} <= '0;
        end else if (step_q != LAST && step_q < cnt_q) begin
            case (op_q)
                OP_GET: if (opnd_q == FREQ_W'(step_q)) begin
                    hit_v <= 1'b1; hit_f <= rd_freq; hit_vlt <= rd_volt;
                end
                OP_MATCH: if (!hit_v && rd_freq == opnd_q) begin
                    hit_v <= 1'b1; hit_i <= step_q[IDX_W-1:0]; hit_vlt <= rd_volt;
                end
                OP_ROUND: if (rd_freq >= opnd_q) begin
                    if (!ge_v || rd_freq < ge_f) begin
                        ge_v <= 1'b1; ge_f <= rd_freq; ge_vlt <= rd_volt;
                    end
                end else if (!lt_v || rd_freq > lt_f) begin
                    lt_v <= 1'b1; lt_f <= rd_freq; lt_vlt <= rd_volt;
                end
                default: ;
            endcase
        end
    end

    assign busy    = busy_q;
    assign r_valid = r_valid_q;
    assign r_err   = r_err_q;
    assign r_value = r_value_q;
    assign r_volt  = r_volt_q;

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid_q |=> !r_valid_q);
    p_idle_at_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid_q |-> !busy_q);
    p_fall_gives_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> r_valid_q);
    p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid_q && r_err_q) |-> (r_value_q == '0 && r_volt_q == '0));
    p_round_reaches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid_q && !r_err_q && op_q == OP_ROUND && ge_v) |-> (r_value_q >= opnd_q));

endmodule

// File: rtl/opp_table_engine.sv
// Top of the operating-point table engine: unpacks load words into the
// per-cluster store and runs queries through the scan sequencer.
// Assumes: NUM_CL is a power of two; word layout is volt above raw freq.
module opp_table_engine #(
    parameter int NUM_CL  = 2,
    parameter int MAX_PTS = 8,
    parameter int RAW_W   = 20,
    parameter int VOLT_W  = 12,
    parameter int SCALE   = 20,
    localparam int FREQ_W = RAW_W + $clog2(SCALE),
    localparam int CL_W   = $clog2(NUM_CL),
    localparam int IDX_W  = $clog2(MAX_PTS),
    localparam int CNT_W  = $clog2(MAX_PTS + 1),
    localparam int WORD_W = RAW_W + VOLT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              ld_ok,
    input  logic [CL_W-1:0]   ld_cluster,
    input  logic [IDX_W-1:0]  ld_index,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              q_valid,
    input  logic [CL_W-1:0]   q_cluster,
    input  logic [1:0]        q_op,
    input  logic [FREQ_W-1:0] q_operand,
    output logic              q_busy,
    output logic              r_valid,
    output logic              r_err,
    output logic [FREQ_W-1:0] r_value,
    output logic [VOLT_W-1:0] r_volt
);

    logic [FREQ_W-1:0] wr_freq, rd_freq;
    logic [VOLT_W-1:0] wr_volt, rd_volt;
    logic [CL_W-1:0]   rd_cluster;
    logic [IDX_W-1:0]  rd_index;
    logic [CNT_W-1:0]  cnt_value;

    opp_unpack #(
        .RAW_W(RAW_W), .VOLT_W(VOLT_W), .SCALE(SCALE), .FREQ_W(FREQ_W)
    ) u_unpack (
        .word(ld_word), .freq(wr_freq), .volt(wr_volt)
    );

    opp_store #(
        .NUM_CL(NUM_CL), .MAX_PTS(MAX_PTS), .FREQ_W(FREQ_W), .VOLT_W(VOLT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(ld_valid), .wr_ok(ld_ok), .wr_cluster(ld_cluster),
        .wr_index(ld_index), .wr_freq(wr_freq), .wr_volt(wr_volt),
        .rd_cluster(rd_cluster), .rd_index(rd_index),
        .rd_freq(rd_freq), .rd_volt(rd_volt),
        .cnt_cluster(q_cluster), .cnt_value(cnt_value)
    );

    opp_scan #(
        .NUM_CL(NUM_CL), .MAX_PTS(MAX_PTS), .FREQ_W(FREQ_W), .VOLT_W(VOLT_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n),
        .q_valid(q_valid), .q_cluster(q_cluster), .q_op(q_op),
        .q_operand(q_operand), .cnt_in(cnt_value),
        .rd_cluster(rd_cluster), .rd_index(rd_index),
        .rd_freq(rd_freq), .rd_volt(rd_volt),
        .busy(q_busy), .r_valid(r_valid), .r_err(r_err),
        .r_value(r_value), .r_volt(r_volt)
    );

endmodule

// File: tb/test_opp_table_engine.sv
module test_opp_table_engine;

    localparam int FREQ_W  = 25;
    localparam int VOLT_W  = 12;
    localparam int MAX_PTS = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0, ld_ok = 1'b0;
    logic              ld_cluster = 1'b0;
    logic [2:0]        ld_index = '0;
    logic [31:0]       ld_word = '0;
    logic              q_valid = 1'b0, q_cluster = 1'b0;
    logic [1:0]        q_op = '0;
    logic [FREQ_W-1:0] q_operand = '0;
    logic              q_busy, r_valid, r_err;
    logic [FREQ_W-1:0] r_value;
    logic [VOLT_W-1:0] r_volt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    opp_table_engine i_opp_table_engine (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_ok(ld_ok), .ld_cluster(ld_cluster),
        .ld_index(ld_index), .ld_word(ld_word),
        .q_valid(q_valid), .q_cluster(q_cluster), .q_op(q_op),
        .q_operand(q_operand), .q_busy(q_busy),
        .r_valid(r_valid), .r_err(r_err), .r_value(r_value), .r_volt(r_volt)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        cl;
        logic [1:0]  op;
        logic [31:0] opnd;
        logic        err;
        logic [31:0] val;
        logic [15:0] volt;
    } vec_t;

    // Cluster 0 holds 1000000/900, 500000/800, 1200000/1000, 500000/850, 800000/870.
    // Cluster 1 holds 700000/750, 20971500/4095, 400000/700.
    localparam int NVEC = 21;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1,  1'b0, 2'd0, 32'd0,        1'b0, 32'd1000000,  16'd900},  // R1
        '{4'd1,  1'b0, 2'd0, 32'd4,        1'b0, 32'd800000,   16'd870},  // R1
        '{4'd3,  1'b0, 2'd0, 32'd5,        1'b1, 32'd0,        16'd0},    // R3 word after failed load absent
        '{4'd5,  1'b0, 2'd0, 32'd100,      1'b1, 32'd0,        16'd0},    // R5
        '{4'd6,  1'b0, 2'd1, 32'd500000,   1'b0, 32'd1,        16'd800},  // R6 first of duplicates
        '{4'd6,  1'b0, 2'd1, 32'd1200000,  1'b0, 32'd2,        16'd1000}, // R6
        '{4'd3,  1'b0, 2'd1, 32'd1400000,  1'b1, 32'd0,        16'd0},    // R3
        '{4'd7,  1'b0, 2'd1, 32'd123,      1'b1, 32'd0,        16'd0},    // R7
        '{4'd8,  1'b0, 2'd2, 32'd600000,   1'b0, 32'd800000,   16'd870},  // R8
        '{4'd8,  1'b0, 2'd2, 32'd500000,   1'b0, 32'd500000,   16'd800},  // R8 tie keeps lower index
        '{4'd8,  1'b0, 2'd2, 32'd0,        1'b0, 32'd500000,   16'd800},  // R8
        '{4'd9,  1'b0, 2'd2, 32'd1300000,  1'b0, 32'd1200000,  16'd1000}, // R9
        '{4'd8,  1'b0, 2'd2, 32'd1000001,  1'b0, 32'd1200000,  16'd1000}, // R8
        '{4'd1,  1'b1, 2'd0, 32'd1,        1'b0, 32'd20971500, 16'd4095}, // R1 full-scale word
        '{4'd2,  1'b1, 2'd0, 32'd2,        1'b0, 32'd400000,   16'd700},  // R2 out-of-order load skipped
        '{4'd2,  1'b1, 2'd0, 32'd3,        1'b1, 32'd0,        16'd0},    // R2
        '{4'd9,  1'b1, 2'd2, 32'd21000000, 1'b0, 32'd20971500, 16'd4095}, // R9
        '{4'd8,  1'b1, 2'd2, 32'd450000,   1'b0, 32'd700000,   16'd750},  // R8
        '{4'd6,  1'b1, 2'd1, 32'd700000,   1'b0, 32'd0,        16'd750},  // R6
        '{4'd4,  1'b1, 2'd1, 32'd1000000,  1'b1, 32'd0,        16'd0},    // R4 value only in cluster 0
        '{4'd12, 1'b0, 2'd3, 32'd0,        1'b1, 32'd0,        16'd0}     // R12
    };

    task automatic check(input bit ok, input int req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called and returns at a falling edge.
    task automatic load(input bit cl, input int idx, input int raw, input int volt, input bit ok);
        ld_valid   = 1'b1;
        ld_ok      = ok;
        ld_cluster = cl;
        ld_index   = idx[2:0];
        ld_word    = {volt[11:0], raw[19:0]};
        @(negedge clk);
        ld_valid   = 1'b0;
    endtask

    // Called and returns at a falling edge; checks timing (R11) and the result.
    task automatic query(input bit cl, input int op, input int opnd, input bit e_err,
                         input int e_val, input int e_volt, input int req);
        bit lat_ok;
        lat_ok    = 1'b1;
        q_valid   = 1'b1;
        q_cluster = cl;
        q_op      = op[1:0];
        q_operand = opnd[FREQ_W-1:0];
        @(negedge clk);
        q_valid   = 1'b0;
        for (int k = 0; k < MAX_PTS; k++) begin
            @(negedge clk);
            if (r_valid || !q_busy) lat_ok = 1'b0;
        end
        @(negedge clk);
        if (!r_valid || q_busy) lat_ok = 1'b0;
        check(r_err == e_err && r_value == FREQ_W'(e_val) && r_volt == VOLT_W'(e_volt),
              req, $sformatf("op %0d operand %0d err/volt %0d/%0d exp %0d/%0d",
                             op, opnd, r_err, r_volt, e_err, e_volt),
              longint'(r_value), longint'(e_val));
        @(negedge clk);
        if (r_valid) lat_ok = 1'b0;
        check(lat_ok, 11, "R11 result pulse after 9 edges", longint'(lat_ok), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog expired: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 idle after reset
        check(!q_busy && !r_valid, 13, "R13 idle after reset", {q_busy, r_valid}, 0);
        // R10 empty table rounds to error
        query(1'b0, 2, 500000, 1'b1, 0, 0, 10);

        // Fill cluster 0, then a failed load, then a word that must be dropped (R3).
        load(1'b0, 0, 50000, 900, 1'b1);
        load(1'b0, 1, 25000, 800, 1'b1);
        load(1'b0, 2, 60000, 1000, 1'b1);
        load(1'b0, 3, 25000, 850, 1'b1);
        load(1'b0, 4, 40000, 870, 1'b1);
        load(1'b0, 5, 0, 0, 1'b0);
        load(1'b0, 5, 70000, 990, 1'b1);
        // Cluster 1 with an out-of-order load in the middle (R2).
        load(1'b1, 0, 35000, 750, 1'b1);
        load(1'b1, 1, 20'hFFFFF, 4095, 1'b1);
        load(1'b1, 5, 10000, 600, 1'b1);
        load(1'b1, 2, 20000, 700, 1'b1);

        for (int v = 0; v < NVEC; v++)
            query(VECS[v].cl, int'(VECS[v].op), int'(VECS[v].opnd), VECS[v].err,
                  int'(VECS[v].val), int'(VECS[v].volt), int'(VECS[v].req));

        // R11: a second query raised while busy is dropped.
        begin
            int pulses;
            pulses    = 0;
            q_valid   = 1'b1; q_cluster = 1'b0; q_op = 2'd0; q_operand = '0;
            @(negedge clk);
            q_cluster = 1'b1; q_op = 2'd2; q_operand = 25'd450000;
            @(negedge clk);
            q_valid   = 1'b0;
            for (int k = 0; k < 3 * MAX_PTS; k++) begin
                if (r_valid) begin
                    pulses++;
                    check(!r_err && r_value == FREQ_W'(1000000), 11,
                          "R11 in-flight query result kept", longint'(r_value), 1000000);
                end
                @(negedge clk);
            end
            check(pulses == 1 && !q_busy, 11, "R11 query during busy ignored",
                  pulses, 1);
        end

        // R13 / R3: reset clears tables and the seal.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        query(1'b0, 0, 0, 1'b1, 0, 0, 13);
        load(1'b0, 0, 1234, 321, 1'b1);
        query(1'b0, 0, 0, 1'b0, 24680, 321, 3);

        // R2: a full table ignores a further load even at the wrapped index 0.
        for (int i = 0; i < MAX_PTS; i++)
            load(1'b1, i, 1000 * (i + 1), 100 + i, 1'b1);
        load(1'b1, 0, 9999, 555, 1'b1);
        query(1'b1, 0, 0, 1'b0, 20000, 100, 2);
        query(1'b1, 0, 7, 1'b0, 160000, 107, 2);
        query(1'b1, 2, 170000, 1'b0, 160000, 107, 9);
        // R4: cluster 0 unaffected by cluster 1 loads
        query(1'b0, 2, 0, 1'b0, 24680, 321, 4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule